// File: doc/BRIEF.md
# Staircase Inverter Gate Sequencer

This block drives the nine power switches of a single-phase, 23-level stepped inverter at the fundamental frequency. There is no carrier. A phase counter advances once for each strobe on a tick input, so one output period is a fixed number of ticks. The counter value is folded into the first quarter-wave and compared against eleven fixed switching instants. The number of instants already passed gives the step magnitude. The second quarter runs the same instants in reverse, and the second half-cycle repeats the first with the sign flipped.

The signed step level is then mapped to a gate vector in which exactly three devices conduct: one from the left leg, one from the right leg and one from the cascade pair. On every change of level, all gates are first held off for a fixed dead-time, and only then is the new state applied. When the block is disabled or in reset, the phase restarts at zero and the gates rest in the zero-output state. A fault flag guards the decoded vector. If the vector is ever malformed, the gates are pinned to the zero-output state.

Top module: `stair_gate_seq`

## Requirements
- R1: While rst_ni is low, and after it rises, the outputs are as follows until the first tick: gates_o = 9'h02C (S3, S4, SY), level_o = 0 and fault_o = 0.
- R2: The gate vector bits are [0]S1 [1]S2 [2]S3 [3]S4 [4]SX [5]SY [6]SP1 [7]SN1 [8]SN2. gates_o always has either exactly three bits set or no bits set.
- R3: SX and SY are never on together. Level 0 maps to S3+S4+SY, positive levels use SY, and negative levels use SX.
- R4: Positive levels map as follows. +1 SP1,S3,SY; +2 S1,S3,SY; +3 SN2,S4,SY; +4 SN2,SP1,SY; +5 S1,SN2,SY; +6 SN1,S4,SY; +7 SP1,SN1,SY; +8 SN1,S1,SY; +9 S2,S4,SY; +10 S2,SP1,SY; +11 S1,S2,SY.
- R5: Negative levels map as follows. -1 SP1,S2,SX; -2 S4,S2,SX; -3 SN1,S1,SX; -4 SN1,SP1,SX; -5 SN1,S4,SX; -6 SN2,S1,SX; -7 SN2,SP1,SX; -8 SN2,S4,SX; -9 S3,S1,SX; -10 S3,SP1,SX; -11 S3,S4,SX.
- R6: The default period is 10000 ticks. For phase p in the first quarter (p < 2500), the level is the count of instants in {143, 287, 433, 583, 739, 903, 1079, 1271, 1489, 1766, 2225} that are at most p. For other periods, these instants scale by TICKS/10000, rounded.
- R7: For 2500 ≤ p < 5000, the level equals that of phase 5000 − p. For p ≥ 5000, the level is the negation of the level at p − 5000.
- R8: The phase advances by one on each clock edge where tick_i and enable_i are both high, and wraps from TICKS−1 to 0. level_o follows the new phase one clock edge later.
- R9: When level_o changes, gates_o is all zero in that cycle and for DEAD_CYCLES−1 further cycles (DEAD_CYCLES cycles in total). The new state appears one cycle after that.
- R10: When enable_i is low, the block returns to the zero-output state one edge later (gates_o = 9'h02C, level_o = 0), the phase restarts at 0, and ticks are ignored.
- R11: fault_o rises, and gates_o is forced to 9'h02C, if the decoded vector does not have exactly three bits set or has both SX and SY set. With a correct map, fault_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Run enable; low forces the zero state and restarts the phase |
| tick_i | input | 1 | Phase advance strobe, one clock wide |
| gates_o | output | 9 | Gate vector, bit order as in R2 |
| level_o | output | 5 | Signed step level, −11 to +11 |
| fault_o | output | 1 | Decoded vector invalid |

## Verification
A tick strobe is sampled on edge E0, and the phase register moves on that edge. level_o moves on E1, and gates_o drops to zero on E1 when the level changes. With the default dead-time of three cycles, the new three-switch state appears on E4. A disable takes effect on the first edge after enable_i falls. The bench drives inputs on falling edges and keeps its own phase count. It checks the level at the falling edge after E1, checks the zero gap at the falling edges after E1, E2 and E3, and checks the mapped vector after E4. Over one full period plus a wrap, this covers every level of both signs, each mirrored quarter and the half-cycle boundaries.

// File: rtl/stair_pkg.sv
package stair_pkg;
  localparam int unsigned STEPS  = 11;
  localparam int unsigned LVL_W  = 5;
  localparam int unsigned GATE_W = 9;

  typedef logic signed [LVL_W-1:0] lvl_t;
  typedef logic [GATE_W-1:0]       gate_t;

  localparam int G_S1  = 0;
  localparam int G_S2  = 1;
  localparam int G_S3  = 2;
  localparam int G_S4  = 3;
  localparam int G_SX  = 4;
  localparam int G_SY  = 5;
  localparam int G_SP1 = 6;
  localparam int G_SN1 = 7;
  localparam int G_SN2 = 8;

  function automatic gate_t g3(int a, int b, int c);
    return (gate_t'(1) << a) | (gate_t'(1) << b) | (gate_t'(1) << c);
  endfunction

  localparam gate_t ZERO_STATE = gate_t'(9'h02C);

  // turn-on instants at 10000 ticks/period, asin(k*30/335)/(2*pi)
  function automatic int unsigned base_tick(int unsigned idx);
    case (idx)
      1:       return 143;
      2:       return 287;
      3:       return 433;
      4:       return 583;
      5:       return 739;
      6:       return 903;
      7:       return 1079;
      8:       return 1271;
      9:       return 1489;
      10:      return 1766;
      default: return 2225;
    endcase
  endfunction

  function automatic int unsigned step_tick(int unsigned idx, int unsigned ticks);
    longint unsigned p;
    p = longint'(base_tick(idx));
    p = p * longint'(ticks) + 64'd5000;
    return int'(p / 64'd10000);
  endfunction
endpackage

// File: rtl/stair_phase_timer.sv
module stair_phase_timer #(
  parameter int unsigned TICKS = 10000,
  parameter int unsigned PW    = $clog2(TICKS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          enable_i,
  input  logic          tick_i,
  output logic [PW-1:0] phase_o
);
  localparam logic [PW-1:0] LAST = PW'(TICKS - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       phase_o <= '0;
    else if (!enable_i) phase_o <= '0;
    else if (tick_i)    phase_o <= (phase_o == LAST) ? '0 : phase_o + PW'(1);
  end
endmodule

// File: rtl/stair_level_finder.sv
module stair_level_finder import stair_pkg::*; #(
  parameter int unsigned TICKS = 10000,
  parameter int unsigned PW    = $clog2(TICKS)
) (
  input  logic [PW-1:0] phase_i,
  output lvl_t          level_o
);
  localparam int unsigned HALF = TICKS / 2;
  localparam int unsigned QTR  = TICKS / 4;

  logic          neg_half;
  logic [PW-1:0] in_half;
  logic [PW-1:0] fold;
  logic [STEPS-1:0] above;
  logic [3:0]    cnt;

  always_comb begin
    neg_half = (phase_i >= PW'(HALF));
    in_half  = neg_half ? phase_i - PW'(HALF) : phase_i;
    fold     = (in_half >= PW'(QTR)) ? PW'(HALF) - in_half : in_half;
  end

  for (genvar i = 0; i < STEPS; i++) begin : g_cmp
    localparam logic [PW-1:0] THR = PW'(step_tick(i + 1, TICKS));
    assign above[i] = (fold >= THR);
  end

  always_comb begin
    cnt = '0;
    for (int i = 0; i < STEPS; i++) cnt = cnt + {3'b000, above[i]};
  end

  assign level_o = neg_half ? -lvl_t'({1'b0, cnt}) : lvl_t'({1'b0, cnt});
endmodule

// File: rtl/stair_gate_map.sv
module stair_gate_map import stair_pkg::*; (
  input  lvl_t  level_i,
  output gate_t gates_o,
  output logic  bad_o
);
  always_comb begin
    case (level_i)
      lvl_t'(0):   gates_o = g3(G_S3,  G_S4,  G_SY);
      lvl_t'(1):   gates_o = g3(G_SP1, G_S3,  G_SY);
      lvl_t'(2):   gates_o = g3(G_S1,  G_S3,  G_SY);
      lvl_t'(3):   gates_o = g3(G_SN2, G_S4,  G_SY);
      lvl_t'(4):   gates_o = g3(G_SN2, G_SP1, G_SY);
      lvl_t'(5):   gates_o = g3(G_S1,  G_SN2, G_SY);
      lvl_t'(6):   gates_o = g3(G_SN1, G_S4,  G_SY);
      lvl_t'(7):   gates_o = g3(G_SP1, G_SN1, G_SY);
      lvl_t'(8):   gates_o = g3(G_SN1, G_S1,  G_SY);
      lvl_t'(9):   gates_o = g3(G_S2,  G_S4,  G_SY);
      lvl_t'(10):  gates_o = g3(G_S2,  G_SP1, G_SY);
      lvl_t'(11):  gates_o = g3(G_S1,  G_S2,  G_SY);
      lvl_t'(-1):  gates_o = g3(G_SP1, G_S2,  G_SX);
      lvl_t'(-2):  gates_o = g3(G_S4,  G_S2,  G_SX);
      lvl_t'(-3):  gates_o = g3(G_SN1, G_S1,  G_SX);
      lvl_t'(-4):  gates_o = g3(G_SN1, G_SP1, G_SX);
      lvl_t'(-5):  gates_o = g3(G_SN1, G_S4,  G_SX);
      lvl_t'(-6):  gates_o = g3(G_SN2, G_S1,  G_SX);
      lvl_t'(-7):  gates_o = g3(G_SN2, G_SP1, G_SX);
      lvl_t'(-8):  gates_o = g3(G_SN2, G_S4,  G_SX);
      lvl_t'(-9):  gates_o = g3(G_S3,  G_S1,  G_SX);
      lvl_t'(-10): gates_o = g3(G_S3,  G_SP1, G_SX);
      lvl_t'(-11): gates_o = g3(G_S3,  G_S4,  G_SX);
      default:     gates_o = '0;
    endcase
  end

  assign bad_o = ($countones(gates_o) != 3) || (gates_o[G_SX] && gates_o[G_SY]);
endmodule

// File: rtl/stair_gate_seq.sv
module stair_gate_seq import stair_pkg::*; #(
  parameter int unsigned TICKS       = 10000,
  parameter int unsigned DEAD_CYCLES = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    enable_i,
  input  logic                    tick_i,
  output logic [GATE_W-1:0]       gates_o,
  output logic signed [LVL_W-1:0] level_o,
  output logic                    fault_o
);
  localparam int unsigned PW = $clog2(TICKS);
  localparam int unsigned DW = $clog2(DEAD_CYCLES + 1);

  logic [PW-1:0] phase;
  lvl_t          target;
  lvl_t          cur_q;
  gate_t         mapped;
  logic          bad;
  logic [DW-1:0] dead_q;
  gate_t         gates_q;
  logic          fault_q;

  stair_phase_timer #(.TICKS(TICKS), .PW(PW)) u_timer (
    .clk_i, .rst_ni, .enable_i, .tick_i, .phase_o(phase)
  );

  stair_level_finder #(.TICKS(TICKS), .PW(PW)) u_finder (
    .phase_i(phase), .level_o(target)
  );

  stair_gate_map u_map (
    .level_i(cur_q), .gates_o(mapped), .bad_o(bad)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q   <= '0;
      dead_q  <= '0;
      gates_q <= ZERO_STATE;
      fault_q <= 1'b0;
    end else if (!enable_i) begin
      cur_q   <= '0;
      dead_q  <= '0;
      gates_q <= ZERO_STATE;
      fault_q <= 1'b0;
    end else if (target != cur_q) begin
      // break before make: all devices off for the dead window
      cur_q   <= target;
      dead_q  <= DW'(DEAD_CYCLES);
      gates_q <= '0;
    end else if (dead_q > DW'(1)) begin
      dead_q  <= dead_q - DW'(1);
      gates_q <= '0;
    end else begin
      dead_q  <= '0;
      gates_q <= bad ? ZERO_STATE : mapped;
      fault_q <= bad;
    end
  end

  assign gates_o = gates_q;
  assign level_o = cur_q;
  assign fault_o = fault_q;
endmodule

// File: rtl/stair_gate_seq_chk.sv
module stair_gate_seq_chk import stair_pkg::*; (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    enable_i,
  input logic [GATE_W-1:0]       gates_i,
  input logic signed [LVL_W-1:0] level_i,
  input logic                    fault_i
);
  a_r2_three_or_none: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(gates_i) == 3) || (gates_i == '0));

  a_r3_cascade_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gates_i[G_SX] && gates_i[G_SY]));

  a_r3_sign_leg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gates_i != '0) |-> ((level_i < 0) ? gates_i[G_SX] : gates_i[G_SY]));

  a_r8_unit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && $past(enable_i)) |->
      ((int'(level_i) - int'($past(level_i)) <= 1) &&
       (int'($past(level_i)) - int'(level_i) <= 1)));

  a_r9_break_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && (level_i != $past(level_i))) |-> (gates_i == '0));

  a_r10_disable_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> ((gates_i == ZERO_STATE) && (level_i == '0)));

  a_r11_no_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_i);
endmodule

bind stair_gate_seq stair_gate_seq_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .enable_i(enable_i),
  .gates_i (gates_o),
  .level_i (level_o),
  .fault_i (fault_o)
);

// File: tb/stair_gate_seq_bench.sv
`timescale 1ns/1ps
module stair_gate_seq_bench;
  localparam int T    = 10000;
  localparam int HALF = T / 2;
  localparam int QTR  = T / 4;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       enable_i = 1'b0;
  logic       tick_i = 1'b0;
  logic [8:0] gates_o;
  logic signed [4:0] level_o;
  logic       fault_o;

  int n_chk = 0;
  int n_fail = 0;
  int p_model = 0;
  int prev_lvl = 0;

  always #10 clk = ~clk;

  stair_gate_seq u_stair_gate_seq (
    .clk_i(clk), .rst_ni, .enable_i, .tick_i, .gates_o, .level_o, .fault_o
  );

  int thr [11] = '{143, 287, 433, 583, 739, 903, 1079, 1271, 1489, 1766, 2225};

  function automatic int model_level(int p);
    int h, f, k;
    h = (p < HALF) ? p : p - HALF;
    f = (h >= QTR) ? HALF - h : h;
    k = 0;
    for (int i = 0; i < 11; i++) if (f >= thr[i]) k++;
    return (p < HALF) ? k : -k;
  endfunction

  // bits: S1=0 S2=1 S3=2 S4=3 SX=4 SY=5 SP1=6 SN1=7 SN2=8
  function automatic int exp_gates(int l);
    case (l)
      0:   return 4 + 8 + 32;
      1:   return 64 + 4 + 32;
      2:   return 1 + 4 + 32;
      3:   return 256 + 8 + 32;
      4:   return 256 + 64 + 32;
      5:   return 1 + 256 + 32;
      6:   return 128 + 8 + 32;
      7:   return 64 + 128 + 32;
      8:   return 128 + 1 + 32;
      9:   return 2 + 8 + 32;
      10:  return 2 + 64 + 32;
      11:  return 1 + 2 + 32;
      -1:  return 64 + 2 + 16;
      -2:  return 8 + 2 + 16;
      -3:  return 128 + 1 + 16;
      -4:  return 128 + 64 + 16;
      -5:  return 128 + 8 + 16;
      -6:  return 256 + 1 + 16;
      -7:  return 256 + 64 + 16;
      -8:  return 256 + 8 + 16;
      -9:  return 4 + 1 + 16;
      -10: return 4 + 64 + 16;
      default: return 4 + 8 + 16;
    endcase
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_tick();
    int nl;
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
    p_model = (p_model + 1) % T;
    nl = model_level(p_model);
    @(negedge clk);
    chk((p_model < QTR) ? "R6" : "R7", "level", int'(level_o), nl);
    chk("R11", "fault", int'(fault_o), 0);
    if (nl != prev_lvl) begin
      chk("R9", "gap0", int'(gates_o), 0);
      @(negedge clk);
      chk("R9", "gap1", int'(gates_o), 0);
      @(negedge clk);
      chk("R9", "gap2", int'(gates_o), 0);
      @(negedge clk);
      chk((nl > 0) ? "R4" : (nl < 0) ? "R5" : "R3", "gates", int'(gates_o), exp_gates(nl));
      chk("R2", "popcount", $countones(gates_o), 3);
    end else begin
      chk("R8", "steady gates", int'(gates_o), exp_gates(nl));
    end
    prev_lvl = nl;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset gates", int'(gates_o), 9'h02C);
    chk("R1", "reset level", int'(level_o), 0);
    chk("R1", "reset fault", int'(fault_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    enable_i = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "idle gates", int'(gates_o), 9'h02C);
    chk("R1", "idle level", int'(level_o), 0);

    // full period plus wrap
    for (int n = 0; n < T + 200; n++) do_tick();

    // run into a high positive level, then disable
    while (p_model != 1300) do_tick();
    chk("R6", "pre-disable level", int'(level_o), 8);
    enable_i = 1'b0;
    @(negedge clk);
    chk("R10", "disable gates", int'(gates_o), 9'h02C);
    chk("R10", "disable level", int'(level_o), 0);
    for (int n = 0; n < 5; n++) begin
      tick_i = 1'b1;
      @(negedge clk);
      tick_i = 1'b0;
      @(negedge clk);
      chk("R10", "tick ignored level", int'(level_o), 0);
      chk("R10", "tick ignored gates", int'(gates_o), 9'h02C);
    end
    enable_i = 1'b1;
    @(negedge clk);
    p_model = 0;
    prev_lvl = 0;
    // phase restarted: first step must reappear at tick 143
    for (int n = 0; n < 300; n++) do_tick();
    chk("R10", "restart level", int'(level_o), 2);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule